// File: doc/BRIEF.md
# Base-Cell Pattern Test Engine

This block is a built-in test sequencer for a single-bit-wide memory arranged as a grid of 2^ROW_BITS rows by 2^COL_BITS columns. It runs one of four background-based pattern tests: an alternating checkerboard, a walking base cell, a galloping base cell, and a rotating diagonal. Each test writes a background of a selectable polarity and places complemented cells on it. The engine then reads the array back and compares every read against the value it computed for that cell.

A test starts from a one-cycle `start` request while the engine is idle. The test selection, the background polarity and the stop-on-failure choice are captured at that moment. The engine issues one memory access per cycle and holds on to the address of the first mismatching read. At the end it marks completion with a one-cycle `done` pulse. The memory under test must return read data in the cycle after `mem_re` is asserted.

Top module: `bpt_engine`

## Requirements
- R1: After synchronous reset, `done`, `fail`, `mem_we` and `mem_re` are low and `fail_addr` is zero.
- R2: Test select 0 (checkerboard) writes every cell with `bg_val ^ row[0] ^ col[0]`, reads the whole array, then writes and reads it again with every value inverted. That makes 4N accesses. The cell address is `{row, col}` with the row in the upper bits, and every access takes one cycle.
- R3: Test select 1 (walking) fills all N cells with the background. For each base address from 0 upward it writes the complement to the base, reads every other cell in ascending order, reads the base last, and writes the background back to the base. That makes N + N(N+2) accesses.
- R4: Test select 2 (galloping) uses the same fill and base placement as walking. After each read of another cell, taken in ascending order, it reads the base again, and then restores the base. That makes N + 2N·N accesses.
- R5: Test select 3 (diagonal) runs one pass for each shift s from 0 to COLS-1. Each pass writes every cell, putting the complement of the background where `col == (row + s) mod COLS` and the background elsewhere, and then reads all cells. That makes 2N·COLS accesses.
- R6: Every read is compared with the complement of the background for the active base or diagonal cell, with the background for any other cell, and with the pattern value in the checkerboard test. On a fault-free memory `fail` stays low.
- R7: The first mismatch sets `fail` two cycles after the failing read is issued. It also captures that read's address in `fail_addr`. Both hold until the next accepted start.
- R8: With `halt_on_fail` set, no access is issued while `fail` is high, and `done` pulses in the same cycle `fail` rises or in the cycle after. With it clear, the test runs its full access count.
- R9: `start` is ignored while a test runs. The selection, polarity and halt choice in use are the values present when the test was accepted.
- R10: `done` is high for exactly one cycle, T+1 cycles after the accepting edge, where T is the test's access count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken only while idle |
| test_sel | input | 2 | 0 checkerboard, 1 walking, 2 galloping, 3 diagonal |
| bg_val | input | 1 | Background polarity |
| halt_on_fail | input | 1 | Stop the test at the first mismatch |
| mem_addr | output | ROW_BITS+COL_BITS | Cell address {row, col} |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 1 | Write data |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 1 | Read data, valid the cycle after mem_re |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ROW_BITS+COL_BITS | Address of the first mismatching read |

## Verification
Each access is visible in the cycle it is issued. Read data returns one cycle later and `fail` follows one cycle after that. `done` arrives T+1 cycles after the start edge, or no later than the cycle after `fail` rises when the engine halts. The bench drives and samples only at falling edges and counts those edges from the accepting edge, so that each result is compared in exactly the cycle it is due. A memory model in the bench keeps a fault-free copy of the array next to an injected stuck cell, and the expected first failing address is the first read on which the two disagree.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    typedef enum logic [1:0] {
        TM_CHECKER = 2'd0,
        TM_WALK    = 2'd1,
        TM_GALPAT  = 2'd2,
        TM_DIAG    = 2'd3
    } tmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_BSET,
        ST_SCAN,
        ST_BREAD,
        ST_BCLR,
        ST_DRAIN
    } st_e;

    // One memory access: strobes plus the write value or the expected read value
    typedef struct packed {
        logic wr;
        logic rd;
        logic val;
    } mop_t;

    typedef struct packed {
        tmode_e mode;
        logic   bg;
        logic   halt;
    } cfg_t;

    function automatic logic checker_bit(logic bg, logic inv, logic r0, logic c0);
        return bg ^ inv ^ r0 ^ c0;
    endfunction

    function automatic logic uses_base(tmode_e m);
        return (m == TM_WALK) || (m == TM_GALPAT);
    endfunction

endpackage

// File: rtl/bpt_seq.sv
module bpt_seq
    import bpt_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    localparam int ADDR_W = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cfg_t              cfg_in,
    input  logic              mismatch,
    output mop_t              op,
    output logic [ADDR_W-1:0] op_addr,
    output logic              accept,
    output logic              done,
    output cfg_t              cfg_o
);

    st_e                 state_q;
    cfg_t                cfg_q;
    logic [ADDR_W-1:0]   cur_q, base_q;
    logic [COL_BITS-1:0] shift_q;
    logic                inv_q, gsub_q, done_q;

    logic [ROW_BITS-1:0] cur_row;
    logic [COL_BITS-1:0] cur_col, diag_col;
    logic [ADDR_W-1:0]   diag_sum, first_other;
    logic [ADDR_W:0]     n1, n2, nxt_other;
    logic                fill_bit, last_cell, last_base, last_shift, last_other;
    logic                galpat, abort;

    assign cur_row     = cur_q[ADDR_W-1:COL_BITS];
    assign cur_col     = cur_q[COL_BITS-1:0];
    assign diag_sum    = ADDR_W'(cur_row) + ADDR_W'(shift_q);
    assign diag_col    = diag_sum[COL_BITS-1:0];
    assign last_cell   = &cur_q;
    assign last_base   = &base_q;
    assign last_shift  = &shift_q;
    assign galpat      = (cfg_q.mode == TM_GALPAT);
    assign first_other = (base_q == '0) ? ADDR_W'(1) : '0;
    assign n1          = {1'b0, cur_q} + (ADDR_W+1)'(1);
    assign n2          = {1'b0, cur_q} + (ADDR_W+1)'(2);
    assign nxt_other   = (n1 == {1'b0, base_q}) ? n2 : n1;
    assign last_other  = nxt_other[ADDR_W];
    assign abort       = cfg_q.halt && mismatch && (state_q != ST_IDLE) && (state_q != ST_DRAIN);
    assign accept      = (state_q == ST_IDLE) && start;
    assign done        = done_q;
    assign cfg_o       = cfg_q;

    always_comb begin
        unique case (cfg_q.mode)
            TM_CHECKER: fill_bit = checker_bit(cfg_q.bg, inv_q, cur_row[0], cur_col[0]);
            TM_DIAG:    fill_bit = (cur_col == diag_col) ? ~cfg_q.bg : cfg_q.bg;
            default:    fill_bit = cfg_q.bg;
        endcase
    end

    always_comb begin
        op      = '0;
        op_addr = cur_q;
        unique case (state_q)
            ST_FILL:  begin op.wr = 1'b1; op.val = fill_bit; end
            ST_READ:  begin op.rd = 1'b1; op.val = fill_bit; end
            ST_BSET:  begin op.wr = 1'b1; op.val = ~cfg_q.bg; op_addr = base_q; end
            ST_SCAN:  begin
                op.rd = 1'b1;
                if (galpat && gsub_q) begin
                    op.val  = ~cfg_q.bg;
                    op_addr = base_q;
                end else begin
                    op.val  = cfg_q.bg;
                end
            end
            ST_BREAD: begin op.rd = 1'b1; op.val = ~cfg_q.bg; op_addr = base_q; end
            ST_BCLR:  begin op.wr = 1'b1; op.val = cfg_q.bg; op_addr = base_q; end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            cur_q   <= '0;
            base_q  <= '0;
            shift_q <= '0;
            inv_q   <= 1'b0;
            gsub_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                state_q <= ST_DRAIN;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (start) begin
                        cfg_q   <= cfg_in;
                        cur_q   <= '0;
                        base_q  <= '0;
                        shift_q <= '0;
                        inv_q   <= 1'b0;
                        gsub_q  <= 1'b0;
                        state_q <= ST_FILL;
                    end
                    ST_FILL: begin
                        cur_q <= cur_q + 1'b1;
                        if (last_cell) state_q <= uses_base(cfg_q.mode) ? ST_BSET : ST_READ;
                    end
                    ST_READ: begin
                        cur_q <= cur_q + 1'b1;
                        if (last_cell) begin
                            if (cfg_q.mode == TM_CHECKER) begin
                                if (inv_q) state_q <= ST_DRAIN;
                                else begin inv_q <= 1'b1; state_q <= ST_FILL; end
                            end else if (last_shift) begin
                                state_q <= ST_DRAIN;
                            end else begin
                                shift_q <= shift_q + 1'b1;
                                state_q <= ST_FILL;
                            end
                        end
                    end
                    ST_BSET: begin
                        cur_q   <= first_other;
                        gsub_q  <= 1'b0;
                        state_q <= ST_SCAN;
                    end
                    ST_SCAN: begin
                        if (galpat && !gsub_q) begin
                            gsub_q <= 1'b1;
                        end else begin
                            gsub_q <= 1'b0;
                            cur_q  <= nxt_other[ADDR_W-1:0];
                            if (last_other) state_q <= galpat ? ST_BCLR : ST_BREAD;
                        end
                    end
                    ST_BREAD: state_q <= ST_BCLR;
                    ST_BCLR: begin
                        base_q  <= base_q + 1'b1;
                        state_q <= last_base ? ST_DRAIN : ST_BSET;
                    end
                    ST_DRAIN: begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) && start |=> $stable(cfg_q)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R10

endmodule

// File: rtl/bpt_cmp.sv
module bpt_cmp #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rd,
    input  logic              exp_bit,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rdata,
    output logic              mismatch,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);

    logic              pend_v, pend_exp;
    logic [ADDR_W-1:0] pend_addr;

    assign mismatch = pend_v && (rdata != pend_exp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_exp  <= 1'b0;
            pend_addr <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
        end else begin
            pend_v    <= rd;
            pend_exp  <= exp_bit;
            pend_addr <= addr;
            if (clr) begin
                fail      <= 1'b0;
                fail_addr <= '0;
            end else if (mismatch && !fail) begin
                fail      <= 1'b1;
                fail_addr <= pend_addr;
            end
        end
    end

    AST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst)
        fail && !clr |=> fail && $stable(fail_addr)); // R7

    AST_FAIL_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> $past(rd, 2)); // R7

endmodule

// File: rtl/bpt_engine.sv
module bpt_engine
    import bpt_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    localparam int ADDR_W = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        test_sel,
    input  logic              bg_val,
    input  logic              halt_on_fail,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_wdata,
    output logic              mem_re,
    input  logic              mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);

    cfg_t              cfg_in, cfg_run;
    mop_t              op;
    logic [ADDR_W-1:0] op_addr;
    logic              accept, mismatch;

    assign cfg_in.mode = tmode_e'(test_sel);
    assign cfg_in.bg   = bg_val;
    assign cfg_in.halt = halt_on_fail;

    bpt_seq #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg_in   (cfg_in),
        .mismatch (mismatch),
        .op       (op),
        .op_addr  (op_addr),
        .accept   (accept),
        .done     (done),
        .cfg_o    (cfg_run)
    );

    bpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .rd        (op.rd),
        .exp_bit   (op.val),
        .addr      (op_addr),
        .rdata     (mem_rdata),
        .mismatch  (mismatch),
        .fail      (fail),
        .fail_addr (fail_addr)
    );

    assign mem_addr  = op_addr;
    assign mem_we    = op.wr;
    assign mem_re    = op.rd;
    assign mem_wdata = op.val;

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
        cfg_run.halt && fail |-> !(mem_we || mem_re)); // R8

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R2

endmodule

// File: tb/sim_bpt_engine.sv
module sim_bpt_engine;

    localparam int RB = 2, CB = 2, AW = RB + CB;
    localparam int ROWS = 1 << RB, COLS = 1 << CB, N = ROWS * COLS;

    logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [1:0]    tsel = 2'd0;
    logic          bgv = 1'b0, halt = 1'b0;
    logic [AW-1:0] mem_addr, fail_addr;
    logic          mem_we, mem_wdata, mem_re, done, fail;
    logic          mem_rdata = 1'b0;

    always #10 clk = ~clk;

    bpt_engine #(.ROW_BITS(RB), .COL_BITS(CB)) u0 (
        .clk(clk), .rst(rst), .start(start), .test_sel(tsel), .bg_val(bgv),
        .halt_on_fail(halt), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    logic good [N];
    bit   fen, fv, seen, track, v_pat, v_grp, v_stop, grp_on, cur_bg, cur_halt, rv;
    int   fa, efa, nrd, nwr, cur_mode, wbase, grp_n, last_rd, prev_oth;
    int   nchk = 0, nbad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ncomp();
        int n = 0;
        for (int a = 0; a < N; a++) if (good[a] != cur_bg) n++;
        return n;
    endfunction

    function automatic bit adj_ok();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                if (c + 1 < COLS && good[r*COLS+c] == good[r*COLS+c+1]) return 1'b0;
                if (r + 1 < ROWS && good[r*COLS+c] == good[(r+1)*COLS+c]) return 1'b0;
            end
        return 1'b1;
    endfunction

    function automatic bit exp_final(input int m, input bit b, input int a);
        int r = a / COLS, c = a % COLS;
        if (m == 0) return ~b ^ bit'((r ^ c) & 1);
        if (m == 3) return (c == (r + COLS - 1) % COLS) ? ~b : b;
        return b;
    endfunction

    function automatic string mtag(input int m);
        case (m)
            0: return "R2 checkerboard";
            1: return "R3 walking";
            2: return "R4 galloping";
            default: return "R5 diagonal";
        endcase
    endfunction

    // Memory under test: one-cycle read latency, optional stuck cell
    always @(posedge clk) begin
        if (mem_we) good[mem_addr] <= mem_wdata;
        if (mem_re) begin
            rv = (fen && int'(mem_addr) == fa) ? fv : good[mem_addr];
            mem_rdata <= rv;
            if (track && !seen && rv != good[mem_addr]) begin
                seen = 1'b1;
                efa  = int'(mem_addr);
            end
        end
    end

    // Access-stream monitor, sampled mid-cycle
    always @(negedge clk) if (track) begin
        if (cur_halt && fail && (mem_we || mem_re)) v_stop = 1'b1;
        if (mem_we) begin
            nwr++;
            if (cur_mode == 1 || cur_mode == 2) begin
                if (mem_wdata != cur_bg) begin
                    wbase = int'(mem_addr); grp_n = 0; grp_on = 1'b1; prev_oth = -1;
                end else if (grp_on && int'(mem_addr) == wbase) begin
                    if (cur_mode == 1 && (grp_n != N || last_rd != wbase)) v_grp = 1'b1;
                    if (cur_mode == 2 && grp_n != 2*(N-1)) v_grp = 1'b1;
                    grp_on = 1'b0;
                end
            end
        end
        if (mem_re) begin
            nrd++;
            case (cur_mode)
                0:       if (!adj_ok()) v_pat = 1'b1;
                3:       if (ncomp() != ROWS) v_pat = 1'b1;
                default: if (ncomp() != 1) v_pat = 1'b1;
            endcase
            if ((cur_mode == 1 || cur_mode == 2) && grp_on) begin
                grp_n++;
                last_rd = int'(mem_addr);
                if (cur_mode == 2) begin
                    if (((grp_n % 2) == 0) != (int'(mem_addr) == wbase)) v_grp = 1'b1;
                end else if (int'(mem_addr) == wbase && grp_n != N) v_grp = 1'b1;
                if (int'(mem_addr) != wbase) begin
                    if (int'(mem_addr) <= prev_oth) v_grp = 1'b1;
                    prev_oth = int'(mem_addr);
                end
            end
        end
    end

    task automatic run(input int m, input bit b, input bit h, input bit fe,
                       input int fadr, input bit fval, input bit mid);
        int t, er, ew, cyc, fcyc, dcyc, bad;
        case (m)
            0: begin t = 4*N;         er = 2*N;       ew = 2*N;    end
            1: begin t = N + N*(N+2); er = N*N;       ew = 3*N;    end
            2: begin t = N + 2*N*N;   er = N*(2*N-2); ew = 3*N;    end
            default: begin t = 2*N*COLS; er = N*COLS; ew = N*COLS; end
        endcase
        fen = fe; fa = fadr; fv = fval; seen = 1'b0; efa = -1;
        nrd = 0; nwr = 0; v_pat = 1'b0; v_grp = 1'b0; v_stop = 1'b0; grp_on = 1'b0;
        cur_mode = m; cur_bg = b; cur_halt = h;
        @(negedge clk);
        tsel = m[1:0]; bgv = b; halt = h; start = 1'b1; track = 1'b1;
        @(negedge clk);
        start = 1'b0; cyc = 0; fcyc = -1; dcyc = -1;
        while (dcyc < 0 && cyc < 4000) begin
            if (fail && fcyc < 0) fcyc = cyc;
            if (done) dcyc = cyc;
            else begin
                if (mid && cyc == 3) begin start = 1'b1; tsel = ~m[1:0]; bgv = ~b; halt = ~h; end
                if (mid && cyc == 4) start = 1'b0;
                @(negedge clk);
                cyc++;
            end
        end
        chk(dcyc >= 0, "R10 watchdog expired", dcyc, t + 1);
        if (h && seen) begin
            chk(dcyc - fcyc >= 0 && dcyc - fcyc <= 1, "R8 done after halt", dcyc - fcyc, 1);
        end else begin
            chk(dcyc == t + 1, "R10 done cycle", dcyc, t + 1);
            chk(nrd == er, mtag(m), nrd, er);
            chk(nwr == ew, mtag(m), nwr, ew);
        end
        chk(fail == seen, "R6 fail flag", int'(fail), int'(seen));
        if (seen) chk(int'(fail_addr) == efa, "R7 first failing address", int'(fail_addr), efa);
        if (h) chk(!v_stop, "R8 access while halted", int'(v_stop), 0);
        if (!fe) begin
            bad = 0;
            for (int a = 0; a < N; a++) if (good[a] != exp_final(m, b, a)) bad++;
            chk(bad == 0, mtag(m), bad, 0);
            chk(!v_pat, mtag(m), int'(v_pat), 0);
            if (m == 1 || m == 2) chk(!v_grp, mtag(m), int'(v_grp), 0);
        end
        if (mid) chk(dcyc == t + 1 && nrd == er, "R9 start during run", nrd, er);
        @(negedge clk);
        chk(!done, "R10 done width", int'(done), 0);
        track = 1'b0; tsel = 2'd0; bgv = 1'b0; halt = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        track = 1'b0; fen = 1'b0;
        for (int a = 0; a < N; a++) good[a] = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !fail && !mem_we && !mem_re, "R1 outputs in reset", int'(done | fail | mem_we | mem_re), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !fail && !mem_we && !mem_re, "R1 idle after reset", int'(done | fail | mem_we | mem_re), 0);
        chk(fail_addr == '0, "R1 fail_addr", int'(fail_addr), 0);

        for (int m = 0; m < 4; m++) begin
            run(m, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
            run(m, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        end
        run(1, 1'b0, 1'b1, 1'b1, 5, 1'b0, 1'b0);
        run(2, 1'b1, 1'b0, 1'b1, 9, 1'b0, 1'b0);
        run(0, 1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b0);
        run(3, 1'b0, 1'b0, 1'b1, N - 1, 1'b1, 1'b0);
        run(1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        run(3, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b1);

        for (int i = 0; i < 12; i++) begin
            int  m  = int'($urandom % 4);
            bit  b  = bit'($urandom % 2);
            bit  h  = bit'($urandom % 2);
            bit  fe = bit'($urandom % 2);
            int  fx = int'($urandom % N);
            bit  fb = bit'($urandom % 2);
            run(m, b, h, fe, fx, fb, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

endmodule